// File: doc/BRIEF.md
# Packed Single-to-Half Precision Converter

This block narrows a vector of IEEE-754 binary32 values to IEEE-754 binary16 values, one converter per lane, all lanes working in parallel. A parameter chooses a narrow build with four lanes or a wide build with eight lanes. The result is always presented as a 128-bit word. The narrow build fills only its low 64 bits.

Each operation carries an 8-bit immediate that picks the rounding direction. One immediate setting defers to a 2-bit dynamic rounding field, which comes from a control/status register outside the block. The conversion covers normal numbers, results that become half-precision subnormals, overflow, underflow, signed zeros, infinities and NaNs. Per-lane exception flags are merged into one flag set for each operation. The datapath is combinational, followed by one register stage. Results, flags and the valid flag all leave that stage together.

Top module: `pk_s2h_cvt`

## Requirements
- R1: A finite binary32 input whose value fits the binary16 normal range is converted with correct rounding. Round-to-nearest breaks ties toward the even result. The sign bit is always kept.
- R2: Rounding is selected by the immediate. When bit 2 is 0, bits 1:0 choose the direction: 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. When bit 2 is 1, the 2-bit dynamic field is used instead, with the same encoding. Immediate bits 7:3 have no effect.
- R3: A finite input whose rounded magnitude exceeds the largest binary16 value (0x7BFF) gives infinity when the direction is nearest, or when it rounds away from zero for that sign. Otherwise it gives the signed largest finite value. The overflow and inexact flags are raised.
- R4: An input below the binary16 normal range is denormalised with correct rounding. The result may become the smallest normal (0x0400) or a signed zero. Tininess is judged before rounding. Underflow and inexact are raised exactly when such a result is inexact.
- R5: Signed zeros and infinities convert to the same-signed zero or infinity, with no flags raised.
- R6: A NaN input gives a NaN with the same sign, exponent all ones, mantissa bit 9 set and mantissa bits 8:0 taken from input mantissa bits 21:13. The invalid flag is raised only when input mantissa bit 22 is 0 (a signalling NaN).
- R7: `valid_o` equals `valid_i` delayed by exactly one clock. Result and flags are captured only in a cycle where `valid_i` is high, and they hold otherwise.
- R8: `flags_o` is the bitwise OR of all lane flags of one operation: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 invalid. Lane i occupies result bits 16*i+15 down to 16*i.
- R9: With four lanes, result bits 127:64 are zero and only input bits 127:0 are used.
- R10: A synchronous active-low reset clears `valid_o`, `half_o` and `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 32*LANES | Packed binary32 lanes, lane 0 in the low bits |
| imm_i | input | 8 | Rounding-select immediate |
| dyn_rc_i | input | 2 | Dynamic rounding field from the control register |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| half_o | output | 128 | Packed binary16 results |
| flags_o | output | 4 | Merged exception flags {invalid, overflow, underflow, inexact} |

## Verification
Every table vector is replicated into all lanes of both the eight-lane and the four-lane instance. A wrong lane slice or a wrong upper-half fill therefore shows up alongside the arithmetic. Inputs are chosen at exact values, at exact ties with even and with odd kept bits, and just past a tie. This separates nearest-even from plain round-half-up and from truncation. The same inputs are then rerun under each immediate code, under the dynamic code, and with junk in the upper immediate bits, which shows which field really steers the rounding. Overflow cases are run with both signs and all four directions, and include the one value that overflows only when rounding carries. The tiny cases reach the smallest subnormal, a tie down to zero, a carry into the smallest normal, and binary32 subnormals, whose only nonzero bits are sticky. Mixed-lane operations, including one where the only exceptional lane lies beyond the narrow build, show the flag merge and confirm that the narrow build ignores the upper input lanes.

// File: rtl/s2h_pkg.sv
// Shared types for the packed single-to-half converter.
// Assumes: binary32 inputs, binary16 outputs, 128-bit result word.
package s2h_pkg;

    localparam int SINGLE_W = 32;
    localparam int HALF_W   = 16;
    localparam int RES_W    = 128;

    // Rounding directions; encoding is shared by the immediate and the dynamic field.
    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_DOWN = 2'd1,
        RM_UP   = 2'd2,
        RM_ZERO = 2'd3
    } rmode_t;

    // Exception flags, bit 0 is inexact.
    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic inx;
    } xflags_t;

endpackage

// File: rtl/s2h_mode_sel.sv
// Picks the rounding direction for one operation.
// Assumes: immediate bit 2 selects the dynamic field; bits 7:3 carry no meaning.
module s2h_mode_sel
    import s2h_pkg::*;
(
    input  logic [7:0] imm_i,
    input  logic [1:0] dyn_i,
    output rmode_t     mode_o
);

    logic unused_imm_hi;
    assign unused_imm_hi = ^imm_i[7:3];

    // Immediate field or dynamic field, chosen by immediate bit 2.
    always_comb begin
        mode_o = imm_i[2] ? rmode_t'(dyn_i) : rmode_t'(imm_i[1:0]);
    end

endmodule

// File: rtl/s2h_lane.sv
// One combinational binary32 -> binary16 converter lane.
// Assumes: mode_i is stable for the operation; clk/rst_n only time the checks.
// Tininess is judged before rounding; binary32 subnormals enter the tiny path.
module s2h_lane
    import s2h_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SINGLE_W-1:0] f_i,
    input  rmode_t              mode_i,
    output logic [HALF_W-1:0]   h_o,
    output xflags_t             x_o
);

    localparam logic [7:0] EXP_MIN_NORM = 8'd113; // binary32 exponent of 2^-14
    localparam logic [7:0] EXP_TOO_BIG  = 8'd143; // binary32 exponent of 2^16
    localparam logic [7:0] EXP_SHIFT0   = 8'd126; // tiny-path shift = 126 - exp
    localparam logic [7:0] EXP_SHCAP    = 8'd94;  // below this, everything is sticky
    localparam logic [14:0] MAG_INF     = 15'h7C00;
    localparam logic [14:0] MAG_MAX     = 15'h7BFF;

    logic        sgn;
    logic [7:0]  exp_in;
    logic [22:0] man;
    logic [7:0]  exp_eff;
    logic [23:0] sig;
    logic        tiny;
    logic        big;
    logic [6:0]  sht;
    logic [41:0] wide;
    logic [9:0]  kept;
    logic        grd;
    logic        stk;
    logic        inc;
    logic [4:0]  hexp;
    logic [14:0] sum;
    logic        rnd_ovf;
    logic        to_inf;

    assign sgn     = f_i[31];
    assign exp_in  = f_i[30:23];
    assign man     = f_i[22:0];
    assign exp_eff = (exp_in == 8'd0) ? 8'd1 : exp_in;
    assign sig     = {exp_in != 8'd0, man};
    assign tiny    = exp_eff < EXP_MIN_NORM;
    assign big     = exp_in >= EXP_TOO_BIG;

    // Gather kept mantissa bits plus guard and sticky for the active path.
    always_comb begin
        sht  = (exp_eff <= EXP_SHCAP) ? 7'd32 : 7'(EXP_SHIFT0 - exp_eff);
        wide = 42'({sig, 32'd0} >> sht);
        if (tiny) begin
            kept = wide[41:32];
            grd  = wide[31];
            stk  = |wide[30:0];
        end else begin
            kept = man[22:13];
            grd  = man[12];
            stk  = |man[11:0];
        end
    end

    // Decide the rounding increment from direction, sign and discarded bits.
    always_comb begin
        unique case (mode_i)
            RM_NEAR: inc = grd & (stk | kept[0]);
            RM_DOWN: inc = sgn & (grd | stk);
            RM_UP:   inc = ~sgn & (grd | stk);
            default: inc = 1'b0;
        endcase
    end

    assign hexp    = tiny ? 5'd0 : 5'(exp_in - 8'd112);
    assign sum     = {hexp, kept} + 15'(inc);
    assign rnd_ovf = sum[14:10] == 5'h1f;
    assign to_inf  = (mode_i == RM_NEAR) | ((mode_i == RM_UP) & ~sgn) | ((mode_i == RM_DOWN) & sgn);

    // Final result and flags per input class.
    always_comb begin
        h_o = {sgn, sum};
        x_o = '0;
        if (exp_in == 8'hff) begin
            if (man == 23'd0) begin
                h_o = {sgn, MAG_INF};
            end else begin
                h_o     = {sgn, 5'h1f, 1'b1, man[21:13]};
                x_o.inv = ~man[22];
            end
        end else if (big || rnd_ovf) begin
            h_o     = {sgn, to_inf ? MAG_INF : MAG_MAX};
            x_o.ovf = 1'b1;
            x_o.inx = 1'b1;
        end else begin
            x_o.inx = grd | stk;
            x_o.unf = tiny & (grd | stk);
        end
    end

    p_sign_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        h_o[15] == f_i[31]);
    p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        x_o.ovf |-> (h_o[14:0] == MAG_INF || h_o[14:0] == MAG_MAX));
    p_unf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        x_o.unf |-> x_o.inx);
    p_unf_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
        x_o.unf |-> (h_o[14:10] <= 5'd1));
    p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (f_i[30:23] == 8'hff && f_i[22:0] != 23'd0) |-> (h_o[14:9] == 6'h3f));

endmodule

// File: rtl/pk_s2h_cvt.sv
// Packed binary32 -> binary16 converter, LANES lanes in parallel.
// Assumes: LANES is 4 or 8; one register stage; synchronous active-low reset.
module pk_s2h_cvt
    import s2h_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_i,
    input  logic [LANES*SINGLE_W-1:0] src_i,
    input  logic [7:0]                imm_i,
    input  logic [1:0]                dyn_rc_i,
    output logic                      valid_o,
    output logic [RES_W-1:0]          half_o,
    output logic [3:0]                flags_o
);

    localparam int PACK_W = LANES * HALF_W;

    rmode_t            mode;
    logic [PACK_W-1:0] pack;
    xflags_t           lane_x [LANES];
    logic [3:0]        or_x;
    logic [PACK_W-1:0] half_q;

    s2h_mode_sel u_mode (
        .imm_i  (imm_i),
        .dyn_i  (dyn_rc_i),
        .mode_o (mode)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        s2h_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .f_i    (src_i[g*SINGLE_W +: SINGLE_W]),
            .mode_i (mode),
            .h_o    (pack[g*HALF_W +: HALF_W]),
            .x_o    (lane_x[g])
        );
    end

    // Merge lane flags into one set for the operation.
    always_comb begin
        or_x = '0;
        for (int i = 0; i < LANES; i++) begin
            or_x = or_x | lane_x[i];
        end
    end

    // Output stage: capture on strobe, valid follows strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            half_q  <= '0;
            flags_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                half_q  <= pack;
                flags_o <= or_x;
            end
        end
    end

    if (PACK_W < RES_W) begin : g_narrow
        assign half_o = {{(RES_W-PACK_W){1'b0}}, half_q};
    end else begin : g_wide
        assign half_o = half_q;
    end

    p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_valid_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(half_o) && $stable(flags_o)));
    p_ovf_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[2] |-> flags_o[0]);

endmodule

// File: tb/pk_s2h_cvt_tb.sv
// Self-checking bench: table walk, then directed reset, timing and lane tests.
module pk_s2h_cvt_tb;

    localparam int NV = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [255:0] src_i = '0;
    logic [7:0]   imm_i = '0;
    logic [1:0]   dyn_rc_i = '0;
    logic         valid_o, valid4_o;
    logic [127:0] half_o, half4_o;
    logic [3:0]   flags_o, flags4_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pk_s2h_cvt #(.LANES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src_i(src_i),
        .imm_i(imm_i), .dyn_rc_i(dyn_rc_i),
        .valid_o(valid_o), .half_o(half_o), .flags_o(flags_o));

    pk_s2h_cvt #(.LANES(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src_i(src_i[127:0]),
        .imm_i(imm_i), .dyn_rc_i(dyn_rc_i),
        .valid_o(valid4_o), .half_o(half4_o), .flags_o(flags4_o));

    // input, immediate, dynamic field, expected half, expected flags, requirement
    localparam logic [31:0] V_IN [NV] = '{
        32'h3F800000, 32'hC0200000, 32'h3F801000, 32'h3F803000,
        32'h3F801000, 32'h3F803000, 32'hBF801001, 32'hBF801001,
        32'hBF801001, 32'h3F801000, 32'h3F803000, 32'h3F803000,
        32'h3F801000, 32'h3F803000, 32'h47C35000, 32'h47C35000,
        32'h47C35000, 32'hC7C35000, 32'hC7C35000, 32'h477FE000,
        32'h477FF000, 32'h477FF000, 32'h38800000, 32'h33800000,
        32'h33000000, 32'h33000000, 32'h00000001, 32'h80000001,
        32'h80000001, 32'h387FF000, 32'h7F800000, 32'hFF800000,
        32'h80000000, 32'h7FC00000, 32'hFF800001, 32'h7FA02000};
    localparam logic [7:0] V_IMM [NV] = '{
        8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h03, 8'h01, 8'h02,
        8'h03, 8'h04, 8'h04, 8'h0C, 8'hFA, 8'hF8, 8'h00, 8'h03,
        8'h01, 8'h02, 8'h01, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00,
        8'h00, 8'h02, 8'h02, 8'h00, 8'h01, 8'h00, 8'h00, 8'h03,
        8'h00, 8'h00, 8'h00, 8'h00};
    localparam logic [1:0] V_DYN [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd2, 2'd3, 2'd1, 2'd0, 2'd3, 2'd0, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd0};
    localparam logic [15:0] V_EXP [NV] = '{
        16'h3C00, 16'hC100, 16'h3C00, 16'h3C02, 16'h3C01, 16'h3C01, 16'hBC01, 16'hBC00,
        16'hBC00, 16'h3C01, 16'h3C01, 16'h3C01, 16'h3C01, 16'h3C02, 16'h7C00, 16'h7BFF,
        16'h7BFF, 16'hFBFF, 16'hFC00, 16'h7BFF, 16'h7C00, 16'h7BFF, 16'h0400, 16'h0001,
        16'h0000, 16'h0001, 16'h0001, 16'h8000, 16'h8001, 16'h0400, 16'h7C00, 16'hFC00,
        16'h8000, 16'h7E00, 16'hFE00, 16'h7F01};
    localparam logic [3:0] V_FLG [NV] = '{
        4'h0, 4'h0, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1,
        4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h5, 4'h5,
        4'h5, 4'h5, 4'h5, 4'h0, 4'h5, 4'h1, 4'h0, 4'h0,
        4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h0, 4'h0,
        4'h0, 4'h0, 4'h8, 4'h8};
    localparam bit [15:0] V_TAG [NV] = '{
        "R1", "R1", "R1", "R1", "R2", "R2", "R2", "R2",
        "R2", "R2", "R2", "R2", "R2", "R2", "R3", "R3",
        "R3", "R3", "R3", "R3", "R3", "R3", "R4", "R4",
        "R4", "R4", "R4", "R4", "R4", "R4", "R5", "R5",
        "R5", "R6", "R6", "R6"};

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One strobed operation; returns at the negedge where the result is valid.
    task automatic run(input logic [255:0] src, input logic [7:0] imm, input logic [1:0] dyn);
        @(negedge clk);
        src_i = src; imm_i = imm; dyn_rc_i = dyn; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", 128'(valid_o), 128'd0);
        chk("R10 reset half", half_o, 128'd0);
        chk("R10 reset flags", 128'(flags_o), 128'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            run({8{V_IN[k]}}, V_IMM[k], V_DYN[k]);
            chk($sformatf("%s vec %0d half8", V_TAG[k], k), half_o, {8{V_EXP[k]}});
            chk($sformatf("%s vec %0d flags", V_TAG[k], k), 128'(flags_o), 128'(V_FLG[k]));
            chk($sformatf("R9 vec %0d half4", k), half4_o, {64'd0, {4{V_EXP[k]}}});
        end

        // R7: valid latency is exactly one clock
        @(negedge clk);
        src_i = {8{32'h3F800000}}; imm_i = 8'h00; valid_i = 1'b1;
        chk("R7 valid low before edge", 128'(valid_o), 128'd0);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R7 valid after one edge", 128'(valid_o), 128'd1);
        chk("R7 half captured", half_o, {8{16'h3C00}});
        @(negedge clk);
        chk("R7 valid drops", 128'(valid_o), 128'd0);

        // R7: outputs hold while strobe is low
        src_i = {8{32'hFF800001}};
        repeat (2) @(negedge clk);
        chk("R7 hold half", half_o, {8{16'h3C00}});
        chk("R7 hold flags", 128'(flags_o), 128'd0);

        // R8: mixed lanes, flags merged across lanes
        run({32'h3F800000, 32'h3F800000, 32'h3F801000, 32'h3F800000,
             32'hFF800001, 32'h3F800000, 32'h3F800000, 32'h47C35000}, 8'h00, 2'd0);
        chk("R8 lanes half8", half_o,
            {16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00, 16'hFE00, 16'h3C00, 16'h3C00, 16'h7C00});
        chk("R8 merged flags8", 128'(flags_o), 128'hD);
        chk("R8 merged flags4", 128'(flags4_o), 128'hD);
        chk("R9 lanes half4", half4_o,
            {64'd0, 16'hFE00, 16'h3C00, 16'h3C00, 16'h7C00});

        // R9: upper input lanes ignored by the narrow build
        run({32'h33000000, {7{32'h00000000}}}, 8'h00, 2'd0);
        chk("R8 top lane only flags8", 128'(flags_o), 128'h3);
        chk("R9 top lane ignored flags4", 128'(flags4_o), 128'h0);
        chk("R9 top lane ignored half4", half4_o, 128'd0);

        // R10: reset in mid-run clears outputs
        run({8{32'h47C35000}}, 8'h00, 2'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset valid", 128'(valid_o), 128'd0);
        chk("R10 mid reset half", half_o, 128'd0);
        chk("R10 mid reset flags", 128'(flags_o), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule